// File: doc/BRIEF.md
# State-Enable Gated Environment-Configuration CSR Unit

This unit holds three environment-configuration control registers: a supervisor copy, a hypervisor copy, and a 32-bit view of the hypervisor copy's upper half. It also holds the three state-enable registers that decide whether software may touch those configuration registers. A single request port carries one CSR read or write per cycle. The request gives a 12-bit address, write data, the requester's privilege level and whether the hart is virtualized. One cycle later the unit answers with either the register contents or a fault code.

Permission is checked against three layers of enable bits. The machine layer is checked first. The hypervisor layer is checked next, and only for virtualized requests. The supervisor layer is checked last, and only for user-mode requests. A fault raised by the hypervisor layer has its own code, so the trap logic can route it to the hypervisor. Every writable register applies a fixed field mask on writes, and the hypervisor mask depends on XLEN. A synthesis parameter removes the gating entirely for cores built without the state-enable feature.

Top module: `envgate_top`

## Requirements
- R1: A request with `req_valid` high gets a response exactly one clock later (`rsp_valid` high). Without a request, `rsp_valid`, `rsp_exc` and `rsp_rdata` are zero. `rsp_exc` encodes 0 = none, 1 = illegal instruction and 2 = virtual-instruction fault. An access that succeeds returns the register value from before the access, and this holds for writes too.
- R2: With `GATE_EN` = 0, every access to the three configuration registers succeeds, whatever the enable bits, privilege or virtualization.
- R3: With `GATE_EN` = 1, an access to 0x10A (supervisor config), 0x60A (hypervisor config) or 0x61A (hypervisor config upper view) raises code 1 if bit 62 of the machine enable register is clear. This check wins over all other causes.
- R4: If the machine bit is set, `req_virt` is high and bit 62 of the hypervisor enable register is clear, a gated access raises code 2.
- R5: If the machine layer and the hypervisor layer both allow the access, a user-mode request (`req_priv` = 0; 1 is supervisor, 3 is machine) raises code 1 when bit 62 of the supervisor enable register is clear. A virtualized user request that both lower layers would deny gets code 2.
- R6: A write to 0x10A changes only bits 0, 5:4, 6 and 7 (mask 0xF1). Every other bit keeps its value.
- R7: A write to 0x60A changes bits 0 and 7:4. With XLEN = 64 it also changes bits 62 and 63. Every other bit keeps its value.
- R8: A read of 0x61A returns bits 63:32 of the hypervisor config. A write to 0x61A places write data bits 31:0 at bits 63:32 and changes only bits 62 and 63.
- R9: The machine (0x30C), hypervisor (0x60C) and supervisor (0x10C) enable registers have only bits 63 and 62 writable, and all other bits read zero. The machine and hypervisor registers also have upper-half views at 0x31C and 0x61C, which read and write bits 63:32. Access to the enable registers is never gated.
- R10: A denied access leaves the target register unchanged and returns zero data.
- R11: After reset all registers are zero, so a gated access raises code 1 until machine software sets the enable bit.
- R12: Any address not listed above raises code 1 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | CSR address |
| req_wdata | input | XLEN | Write data |
| req_priv | input | 2 | Requester privilege (0 U, 1 S, 3 M) |
| req_virt | input | 1 | Requester runs virtualized |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | XLEN | Register value before the access, zero on a fault |
| rsp_exc | output | 2 | Fault code: 0 none, 1 illegal, 2 virtual instruction |

## Verification
Each response is due one clock after its request. The bench drives a request on a falling edge, the unit captures it on the next rising edge, and the monitor samples 2 ns after that rising edge. A write changes the register on the same edge that captures it, so the very next request already sees the new value. The bench's reference model updates its state at the same point, in the same order. Expected responses go into a queue in issue order, and the monitor pops one entry for each response. It compares both the gated instance and a second instance built without gating, which receives the same stimulus.

// File: rtl/envgate_pkg.sv
package envgate_pkg;

    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADR_SCFG  = 12'h10A;
    localparam logic [ADDR_W-1:0] ADR_HCFG  = 12'h60A;
    localparam logic [ADDR_W-1:0] ADR_HCFGH = 12'h61A;
    localparam logic [ADDR_W-1:0] ADR_MEN   = 12'h30C;
    localparam logic [ADDR_W-1:0] ADR_MENH  = 12'h31C;
    localparam logic [ADDR_W-1:0] ADR_HEN   = 12'h60C;
    localparam logic [ADDR_W-1:0] ADR_HENH  = 12'h61C;
    localparam logic [ADDR_W-1:0] ADR_SEN   = 12'h10C;

    localparam int EN_LIVE_BIT = 63;
    localparam int EN_CFG_BIT  = 62;

    localparam logic [REG_W-1:0] EN_WMASK =
        (REG_W'(1) << EN_LIVE_BIT) | (REG_W'(1) << EN_CFG_BIT);
    // fence-ordering bit 0, cache-block invalidate 5:4, clean/flush 6, zero 7
    localparam logic [REG_W-1:0] CFG_LO_WMASK = REG_W'(64'h00F1);
    // page-attribute enable 62, timer-compare enable 63
    localparam logic [REG_W-1:0] CFG_HI_WMASK = REG_W'(64'hC000_0000_0000_0000);

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_ILLEGAL = 2'd1,
        EXC_VIRT    = 2'd2
    } exc_e;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SCFG, SEL_HCFG, SEL_HCFGH,
        SEL_MEN, SEL_MENH, SEL_HEN, SEL_HENH, SEL_SEN
    } sel_e;

    typedef struct packed {
        logic m_cfg;
        logic h_cfg;
        logic s_cfg;
    } gate_bits_t;

    function automatic logic [REG_W-1:0] merge_masked(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic [REG_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic sel_is_gated(input sel_e s);
        return (s == SEL_SCFG) || (s == SEL_HCFG) || (s == SEL_HCFGH);
    endfunction

endpackage

// File: rtl/envgate_decode.sv
module envgate_decode
    import envgate_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    always_comb begin
        unique case (addr)
            ADR_SCFG:  sel = SEL_SCFG;
            ADR_HCFG:  sel = SEL_HCFG;
            ADR_HCFGH: sel = SEL_HCFGH;
            ADR_MEN:   sel = SEL_MEN;
            ADR_MENH:  sel = SEL_MENH;
            ADR_HEN:   sel = SEL_HEN;
            ADR_HENH:  sel = SEL_HENH;
            ADR_SEN:   sel = SEL_SEN;
            default:   sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/envgate_perm.sv
module envgate_perm
    import envgate_pkg::*;
#(
    parameter bit GATE_EN = 1'b1
) (
    input  sel_e       sel,
    input  priv_e      priv,
    input  logic       virt,
    input  gate_bits_t gate,
    output exc_e       exc
);
    generate
        if (GATE_EN) begin : g_chain
            always_comb begin
                if (sel == SEL_NONE) begin
                    exc = EXC_ILLEGAL;
                end else if (!sel_is_gated(sel)) begin
                    exc = EXC_NONE;
                end else if (!gate.m_cfg) begin
                    exc = EXC_ILLEGAL;
                end else if (virt && !gate.h_cfg) begin
                    exc = EXC_VIRT;
                end else if ((priv == PRIV_U) && !gate.s_cfg) begin
                    exc = EXC_ILLEGAL;
                end else begin
                    exc = EXC_NONE;
                end
            end
        end else begin : g_open
            logic unused_ok;
            assign unused_ok = ^{priv, virt, gate};
            assign exc = (sel == SEL_NONE) ? EXC_ILLEGAL : EXC_NONE;
        end
    endgenerate
endmodule

// File: rtl/envgate_regs.sv
module envgate_regs
    import envgate_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  sel_e             sel,
    input  logic [REG_W-1:0] wext,
    output logic [REG_W-1:0] rdata,
    output gate_bits_t       gate
);
    localparam logic [REG_W-1:0] HCFG_WMASK =
        (XLEN == 64) ? (CFG_LO_WMASK | CFG_HI_WMASK) : CFG_LO_WMASK;

    logic [REG_W-1:0] scfg_q, hcfg_q, men_q, hen_q, sen_q;
    logic [REG_W-1:0] whi;

    assign whi = {wext[HALF_W-1:0], {HALF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            scfg_q <= '0;
            hcfg_q <= '0;
            men_q  <= '0;
            hen_q  <= '0;
            sen_q  <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_SCFG:  scfg_q <= merge_masked(scfg_q, wext, CFG_LO_WMASK);
                SEL_HCFG:  hcfg_q <= merge_masked(hcfg_q, wext, HCFG_WMASK);
                SEL_HCFGH: hcfg_q <= merge_masked(hcfg_q, whi, CFG_HI_WMASK);
                SEL_MEN:   men_q  <= merge_masked(men_q, wext, EN_WMASK);
                SEL_MENH:  men_q  <= merge_masked(men_q, whi, EN_WMASK);
                SEL_HEN:   hen_q  <= merge_masked(hen_q, wext, EN_WMASK);
                SEL_HENH:  hen_q  <= merge_masked(hen_q, whi, EN_WMASK);
                SEL_SEN:   sen_q  <= merge_masked(sen_q, wext, EN_WMASK);
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_SCFG:  rdata = scfg_q;
            SEL_HCFG:  rdata = hcfg_q;
            SEL_HCFGH: rdata = {{HALF_W{1'b0}}, hcfg_q[REG_W-1:HALF_W]};
            SEL_MEN:   rdata = men_q;
            SEL_MENH:  rdata = {{HALF_W{1'b0}}, men_q[REG_W-1:HALF_W]};
            SEL_HEN:   rdata = hen_q;
            SEL_HENH:  rdata = {{HALF_W{1'b0}}, hen_q[REG_W-1:HALF_W]};
            SEL_SEN:   rdata = sen_q;
            default:   rdata = '0;
        endcase
    end

    assign gate.m_cfg = men_q[EN_CFG_BIT];
    assign gate.h_cfg = hen_q[EN_CFG_BIT];
    assign gate.s_cfg = sen_q[EN_CFG_BIT];
endmodule

// File: rtl/envgate_top.sv
module envgate_top
    import envgate_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit GATE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]   req_wdata,
    input  logic [1:0]        req_priv,
    input  logic              req_virt,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic [1:0]        rsp_exc
);
    sel_e             sel;
    exc_e             exc;
    gate_bits_t       gate_q;
    logic [REG_W-1:0] rd_full;
    logic [REG_W-1:0] wext;
    logic             grant;
    logic             m_en_w, h_en_w, s_en_w;

    assign wext  = REG_W'(req_wdata);
    assign grant = req_valid && (exc == EXC_NONE);

    assign m_en_w = gate_q.m_cfg;
    assign h_en_w = gate_q.h_cfg;
    assign s_en_w = gate_q.s_cfg;

    envgate_decode u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    envgate_perm #(.GATE_EN(GATE_EN)) u_perm (
        .sel  (sel),
        .priv (priv_e'(req_priv)),
        .virt (req_virt),
        .gate (gate_q),
        .exc  (exc)
    );

    envgate_regs #(.XLEN(XLEN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (grant && req_write),
        .sel   (sel),
        .wext  (wext),
        .rdata (rd_full),
        .gate  (gate_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_exc   <= EXC_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_exc   <= req_valid ? exc : EXC_NONE;
            rsp_rdata <= grant ? rd_full[XLEN-1:0] : '0;
        end
    end
endmodule

// File: rtl/envgate_chk.sv
module envgate_chk
    import envgate_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit GATE_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_priv,
    input logic              req_virt,
    input logic              rsp_valid,
    input logic [XLEN-1:0]   rsp_rdata,
    input logic [1:0]        rsp_exc,
    input logic              m_en_w,
    input logic              h_en_w,
    input logic              s_en_w
);
    logic gated, mapped;
    assign gated  = (req_addr == ADR_SCFG) || (req_addr == ADR_HCFG) ||
                    (req_addr == ADR_HCFGH);
    assign mapped = gated || (req_addr == ADR_MEN) || (req_addr == ADR_MENH) ||
                    (req_addr == ADR_HEN) || (req_addr == ADR_HENH) ||
                    (req_addr == ADR_SEN);

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_exc == 2'd0 && rsp_rdata == '0));
    a_r1_exc_code_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_exc != 2'd3));
    a_r10_denied_no_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_exc != 2'd0) |-> (rsp_rdata == '0));
    a_r12_unmapped_illegal: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mapped) |=> (rsp_exc == 2'd1));

    generate
        if (GATE_EN) begin : g_gated
            a_r3_machine_deny: assert property (@(posedge clk) disable iff (rst)
                (req_valid && gated && !m_en_w) |=> (rsp_exc == 2'd1));
            a_r4_hyp_deny: assert property (@(posedge clk) disable iff (rst)
                (req_valid && gated && m_en_w && req_virt && !h_en_w)
                |=> (rsp_exc == 2'd2));
            a_r5_sup_deny: assert property (@(posedge clk) disable iff (rst)
                (req_valid && gated && m_en_w && (!req_virt || h_en_w) &&
                 req_priv == 2'd0 && !s_en_w) |=> (rsp_exc == 2'd1));
        end else begin : g_open
            a_r2_no_gate: assert property (@(posedge clk) disable iff (rst)
                (req_valid && gated) |=> (rsp_exc == 2'd0));
        end
    endgenerate
endmodule

bind envgate_top envgate_chk #(.XLEN(XLEN), .GATE_EN(GATE_EN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_priv  (req_priv),
    .req_virt  (req_virt),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_exc   (rsp_exc),
    .m_en_w    (m_en_w),
    .h_en_w    (h_en_w),
    .s_en_w    (s_en_w)
);

// File: tb/tb_envgate_top.sv
module tb_envgate_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_virt;
    logic [11:0] req_addr;
    logic [63:0] req_wdata;
    logic [1:0]  req_priv;
    logic        rsp_valid, ng_valid;
    logic [63:0] rsp_rdata, ng_rdata;
    logic [1:0]  rsp_exc, ng_exc;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    envgate_top #(.XLEN(64), .GATE_EN(1'b1)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
        .req_virt(req_virt), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_exc(rsp_exc)
    );

    envgate_top #(.XLEN(64), .GATE_EN(1'b0)) dut_ng (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
        .req_virt(req_virt), .rsp_valid(ng_valid), .rsp_rdata(ng_rdata),
        .rsp_exc(ng_exc)
    );

    typedef struct {
        logic [63:0] men, hen, sen, scfg, hcfg;
    } mst_t;

    typedef struct {
        logic [1:0]  exc;
        logic [63:0] rd;
        logic [1:0]  exc_ng;
        logic [63:0] rd_ng;
        string       tag;
    } exp_t;

    mst_t st_g, st_n;
    exp_t q[$];

    localparam logic [63:0] SM = 64'hC000_0000_0000_0000;
    localparam logic [63:0] LM = 64'h0000_0000_0000_00F1;

    function automatic logic [63:0] mrg(logic [63:0] o, logic [63:0] n, logic [63:0] m);
        return (o & ~m) | (n & m);
    endfunction

    function automatic void model(inout mst_t st, input bit gate, input logic w,
                                  input logic [11:0] a, input logic [63:0] d,
                                  input logic [1:0] p, input logic v,
                                  output logic [1:0] exc, output logic [63:0] rd);
        bit g, mapped;
        logic [63:0] dh;
        g = (a == 12'h10A) || (a == 12'h60A) || (a == 12'h61A);
        mapped = g || (a == 12'h30C) || (a == 12'h31C) || (a == 12'h60C) ||
                 (a == 12'h61C) || (a == 12'h10C);
        dh = d << 32;
        exc = 2'd0;
        rd = 64'd0;
        if (!mapped) exc = 2'd1;
        else if (g && gate) begin
            if (!st.men[62]) exc = 2'd1;
            else if (v && !st.hen[62]) exc = 2'd2;
            else if (p == 2'd0 && !st.sen[62]) exc = 2'd1;
        end
        if (exc != 2'd0) return;
        case (a)
            12'h10A: rd = st.scfg;
            12'h60A: rd = st.hcfg;
            12'h61A: rd = st.hcfg >> 32;
            12'h30C: rd = st.men;
            12'h31C: rd = st.men >> 32;
            12'h60C: rd = st.hen;
            12'h61C: rd = st.hen >> 32;
            default: rd = st.sen;
        endcase
        if (w) begin
            case (a)
                12'h10A: st.scfg = mrg(st.scfg, d, LM);
                12'h60A: st.hcfg = mrg(st.hcfg, d, LM | SM);
                12'h61A: st.hcfg = mrg(st.hcfg, dh, SM);
                12'h30C: st.men  = mrg(st.men, d, SM);
                12'h31C: st.men  = mrg(st.men, dh, SM);
                12'h60C: st.hen  = mrg(st.hen, d, SM);
                12'h61C: st.hen  = mrg(st.hen, dh, SM);
                default: st.sen  = mrg(st.sen, d, SM);
            endcase
        end
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [11:0] a, input logic [63:0] d,
                       input logic [1:0] p, input logic v, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        req_priv  = p;
        req_virt  = v;
        model(st_g, 1'b1, w, a, d, p, v, e.exc, e.rd);
        model(st_n, 1'b0, w, a, d, p, v, e.exc_ng, e.rd_ng);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
        end
    endtask

    // monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (!rst && rsp_valid) begin
                if (q.size() == 0) begin
                    chk("R1 unexpected response", 64'd1, 64'd0);
                end else begin
                    e = q.pop_front();
                    chk({e.tag, " exc"}, 64'(rsp_exc), 64'(e.exc));
                    chk({e.tag, " rdata"}, rsp_rdata, e.rd);
                    chk({e.tag, " R2 ungated exc"}, 64'(ng_exc), 64'(e.exc_ng));
                    chk({e.tag, " R2 ungated rdata"}, ng_rdata, e.rd_ng);
                    chk("R1 ungated valid", 64'(ng_valid), 64'd1);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        req_priv = 0; req_virt = 0;
        st_g = '{default: 64'd0};
        st_n = '{default: 64'd0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R11 reset rsp_exc", 64'(rsp_exc), 64'd0);

        // R11 / R3: gated access refused after reset
        acc(0, 12'h10A, 0, 2'd1, 0, "R11 scfg read after reset");
        acc(0, 12'h60A, 0, 2'd3, 0, "R3 hcfg read machine clear");
        // R9 enable register masks and high views
        acc(1, 12'h30C, '1, 2'd3, 0, "R9 men write ones");
        acc(0, 12'h30C, 0, 2'd3, 0, "R9 men readback");
        acc(1, 12'h31C, 64'h4000_0000, 2'd3, 0, "R9 men high write");
        acc(0, 12'h30C, 0, 2'd3, 0, "R9 men after high write");
        acc(0, 12'h31C, 0, 2'd3, 0, "R9 men high read");
        // R6 supervisor config mask
        acc(1, 12'h10A, '1, 2'd1, 0, "R6 scfg write ones");
        acc(0, 12'h10A, 0, 2'd1, 0, "R6 scfg readback");
        acc(1, 12'h10A, 64'h0F, 2'd1, 0, "R6 scfg partial write");
        acc(0, 12'h10A, 0, 2'd1, 0, "R6 scfg partial readback");
        // R5 supervisor layer for user mode
        acc(0, 12'h10A, 0, 2'd0, 0, "R5 user denied sup clear");
        acc(1, 12'h10C, '1, 2'd1, 0, "R9 sen write ones");
        acc(0, 12'h10C, 0, 2'd0, 1, "R9 sen read ungated virt user");
        acc(0, 12'h10A, 0, 2'd0, 0, "R5 user allowed sup set");
        // R4 hypervisor layer
        acc(0, 12'h10A, 0, 2'd1, 1, "R4 virt denied hyp clear");
        acc(1, 12'h60C, '1, 2'd3, 0, "R9 hen write ones");
        acc(0, 12'h61C, 0, 2'd3, 0, "R9 hen high read");
        acc(0, 12'h10A, 0, 2'd1, 1, "R4 virt allowed hyp set");
        // R7 / R8 hypervisor config and its upper view
        acc(1, 12'h60A, '1, 2'd1, 0, "R7 hcfg write ones");
        acc(0, 12'h60A, 0, 2'd1, 0, "R7 hcfg readback");
        acc(0, 12'h61A, 0, 2'd1, 0, "R8 hcfgh read");
        acc(1, 12'h61A, 0, 2'd1, 0, "R8 hcfgh write zero");
        acc(0, 12'h60A, 0, 2'd1, 0, "R8 hcfg after hcfgh zero");
        acc(1, 12'h61A, 64'h8000_0000, 2'd1, 0, "R8 hcfgh write top bit");
        acc(0, 12'h60A, 0, 2'd1, 0, "R8 hcfg after top bit");
        // R5 ordering: hyp and sup both clear, virtualized user
        acc(1, 12'h60C, 0, 2'd3, 0, "R9 hen clear");
        acc(1, 12'h10C, 0, 2'd1, 0, "R9 sen clear");
        acc(0, 12'h61A, 0, 2'd0, 1, "R5 order hyp before sup");
        acc(0, 12'h10A, 0, 2'd0, 0, "R5 user nonvirt sup clear");
        // R3 ordering: machine clear wins; R10 denied write
        acc(1, 12'h30C, 0, 2'd3, 0, "R3 men clear");
        acc(0, 12'h10A, 0, 2'd0, 1, "R3 machine wins over all");
        acc(1, 12'h10A, 64'h0, 2'd3, 0, "R10 denied scfg write");
        acc(1, 12'h60A, 64'h0, 2'd3, 0, "R10 denied hcfg write");
        acc(1, 12'h30C, SM, 2'd3, 0, "R9 men set again");
        acc(0, 12'h10A, 0, 2'd3, 0, "R10 scfg unchanged");
        acc(0, 12'h60A, 0, 2'd3, 0, "R10 hcfg unchanged");
        // R12 unmapped
        acc(1, 12'h123, '1, 2'd3, 0, "R12 unmapped write");
        acc(0, 12'h30C, 0, 2'd3, 0, "R12 men unaffected");
        idle();
        // R1 gap then back-to-back
        idle();
        acc(0, 12'h10A, 0, 2'd3, 0, "R1 after gap");
        acc(0, 12'h61C, 0, 2'd3, 0, "R1 back to back");
        idle();
        repeat (3) @(negedge clk);
        chk("R1 idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 idle rsp_rdata", rsp_rdata, 64'd0);
        chk("R1 queue drained", 64'(q.size()), 64'd0);
        summary();
        $finish;
    end
endmodule